// File: doc/BRIEF.md
# Horizontal Sync Pulse Counter with Selectable Gate Window

This block measures the horizontal line rate of an incoming video signal. It counts rising edges of the horizontal sync input across a gate window. Firmware compares the resulting number with known video timings to decide whether a mode is valid. The gate window comes from one of two sources. The first is the span between two successive vertical sync rising edges. The second is a fixed interval built from a free 8 µs timebase tick: 2048 ticks (16.384 ms) or 4096 ticks (32.768 ms).

Each time a window closes, the running count is copied into a read-only result register and the running counter starts again from zero. If the running counter would pass its largest value, it stays at that value and a sticky overflow flag is raised. Firmware clears the flag by writing a one to a clear strobe. That write does not touch the running counter.

Top module: `hsync_gate_counter`

## Requirements
- R1: With the gate-select bit at 1, a window closes on every synchronized rising edge of the vertical sync input. The result then equals the number of horizontal sync rising edges seen since the previous vertical sync edge.
- R2: With the gate-select bit at 0, the window length is set by the length bit: 0 selects 2048 tick pulses and 1 selects 4096. Only cycles with the tick input high advance the window.
- R3: After reset, the gate-select bit and the length bit both read 1, the result reads 0 and the overflow flag reads 0.
- R4: The result register changes only at a window close. It then holds its value until the next close. The running counter restarts from zero at each close.
- R5: While the gate-select bit is 0, vertical sync edges neither close a window nor change the result.
- R6: The count is 14 bits wide. 16383 edges in one window give a result of 16383 with the flag low. A further edge in the same window leaves the count at 16383 and sets the overflow flag. The flag stays set until it is cleared.
- R7: A clear write with data 1 lowers the overflow flag. A clear write with data 0 has no effect. A clear write never resets the running count, so edges before and after the write add into one result.
- R8: Both sync inputs pass through two synchronizing flops, and only rising edges count. A level held high for many cycles counts once.
- R9: A horizontal sync edge that falls in the same cycle as a window close is counted in the new window.
- R10: A mode write that changes either mode bit restarts the window timer and the running counter without updating the result. With an internal window, the first close comes on the 2048th or 4096th tick-high clock edge after the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| tick_8us | input | 1 | One-cycle timebase pulse every 8 µs |
| mode_wr | input | 1 | Write strobe for the two mode bits |
| mode_vsync_gate | input | 1 | Gate-select value written (1 = vertical sync window) |
| mode_long_win | input | 1 | Length value written (1 = 4096 ticks) |
| ovf_clr_wr | input | 1 | Write strobe for the overflow clear bit |
| ovf_clr_data | input | 1 | Clear bit value; 1 clears the flag |
| hcount | output | 14 | Latched edge count of the last closed window |
| hcount_ovf | output | 1 | Sticky overflow flag |
| cur_vsync_gate | output | 1 | Current gate-select bit |
| cur_long_win | output | 1 | Current length bit |

## Verification
Consider a sync input driven high before clock edge E1. It shows up as an internal edge after E2 and reaches the running count or the result at E3. For that reason, every check after a sync pulse waits four cycles and samples mid-cycle. Mode and clear writes act on the edge that samples the strobe, and they are checked right after it. Internal windows are checked at an exact cycle offset from the accepting edge: one cycle before the close to confirm the result is unchanged, and on the closing cycle to confirm the new value. Random per-window pulse counts and gaps are compared with the count the bench itself generated.

// File: rtl/hsgc_pkg.sv
package hsgc_pkg;

    // Mode register: gate source and internal window length.
    typedef struct packed {
        logic vsync_gate;
        logic long_win;
    } mode_t;

    localparam mode_t MODE_RESET = '{vsync_gate: 1'b1, long_win: 1'b1};

endpackage

// File: rtl/hsgc_edge_sync.sv
module hsgc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], din};
        rise    = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsgc_window_gen.sv
module hsgc_window_gen
    import hsgc_pkg::*;
#(
    parameter int SHORT_TICKS = 2048,
    parameter int LONG_TICKS  = 4096
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mode_wr,
    input  mode_t mode_wval,
    input  logic  tick,
    input  logic  vs_rise,
    output mode_t mode_o,
    output logic  win_end,
    output logic  restart
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int TW        = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_TICKS - 1);
    localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_TICKS - 1);

    typedef struct packed {
        mode_t         mode;
        logic [TW-1:0] tcnt;
    } win_st_t;

    win_st_t       st_d, st_q;
    logic [TW-1:0] last_tick;
    logic          timer_hit;

    always_comb begin
        st_d      = st_q;
        last_tick = st_q.mode.long_win ? LONG_LAST : SHORT_LAST;
        timer_hit = tick && (st_q.tcnt == last_tick);
        restart   = mode_wr && (mode_wval != st_q.mode);
        win_end   = 1'b0;

        if (restart) begin
            st_d.mode = mode_wval;
            st_d.tcnt = '0;
        end else if (st_q.mode.vsync_gate) begin
            win_end   = vs_rise;
            st_d.tcnt = '0;
        end else begin
            win_end = timer_hit;
            if (tick) begin
                st_d.tcnt = timer_hit ? '0 : st_q.tcnt + 1'b1;
            end
        end

        mode_o = st_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RESET;
            st_q.tcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hsgc_pulse_count.sv
module hsgc_pulse_count #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise,
    input  logic             win_end,
    input  logic             restart,
    input  logic             clr_wr,
    input  logic             clr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] held;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    ovf_set;
    logic    ovf_clr;
    logic [CNT_W-1:0] fresh;

    always_comb begin
        st_d    = st_q;
        ovf_set = 1'b0;
        ovf_clr = clr_wr && clr_data;
        // An edge on the closing cycle opens the new window.
        fresh   = hs_rise ? CNT_ONE : '0;

        if (win_end) begin
            st_d.held = st_q.run;
            st_d.run  = fresh;
        end else if (restart) begin
            st_d.run  = fresh;
        end else if (hs_rise) begin
            if (st_q.run == CNT_MAX) ovf_set  = 1'b1;
            else                     st_d.run = st_q.run + 1'b1;
        end

        // Set has priority over a clear in the same cycle.
        st_d.ovf = ovf_set | (st_q.ovf & ~ovf_clr);

        count_o = st_q.held;
        ovf_o   = st_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsync_gate_counter.sv
module hsync_gate_counter
    import hsgc_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_TICKS = 2048,
    parameter int LONG_TICKS  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             tick_8us,
    input  logic             mode_wr,
    input  logic             mode_vsync_gate,
    input  logic             mode_long_win,
    input  logic             ovf_clr_wr,
    input  logic             ovf_clr_data,
    output logic [CNT_W-1:0] hcount,
    output logic             hcount_ovf,
    output logic             cur_vsync_gate,
    output logic             cur_long_win
);
    localparam int N_CH  = 2;
    localparam int CH_HS = 0;
    localparam int CH_VS = 1;

    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    logic            hs_rise;
    logic            vs_rise;
    logic            win_end;
    logic            restart;
    mode_t           mode_wval;
    mode_t           mode_cur;

    assign raw_in[CH_HS] = hsync_in;
    assign raw_in[CH_VS] = vsync_in;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
        hsgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[ch]),
            .rise (rise[ch])
        );
    end

    assign hs_rise = rise[CH_HS];
    assign vs_rise = rise[CH_VS];

    assign mode_wval.vsync_gate = mode_vsync_gate;
    assign mode_wval.long_win   = mode_long_win;

    hsgc_window_gen #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_wval(mode_wval),
        .tick     (tick_8us),
        .vs_rise  (vs_rise),
        .mode_o   (mode_cur),
        .win_end  (win_end),
        .restart  (restart)
    );

    hsgc_pulse_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_rise (hs_rise),
        .win_end (win_end),
        .restart (restart),
        .clr_wr  (ovf_clr_wr),
        .clr_data(ovf_clr_data),
        .count_o (hcount),
        .ovf_o   (hcount_ovf)
    );

    assign cur_vsync_gate = mode_cur.vsync_gate;
    assign cur_long_win   = mode_cur.long_win;
endmodule

// File: rtl/hsync_gate_counter_chk.sv
module hsync_gate_counter_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_rise,
    input logic             vs_rise,
    input logic             win_end,
    input logic             vgate,
    input logic             clr_wr,
    input logic             clr_data,
    input logic [CNT_W-1:0] hcount,
    input logic             ovf
);
    // R1: in vertical sync mode a close needs a vertical sync edge.
    p_vsync_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vgate && win_end) |-> vs_rise);

    // R4: the result only moves on a window close.
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(hcount));

    // R6: the flag is sticky without a clear.
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(clr_wr && clr_data)) |=> ovf);

    // R6: the flag rises only after a counted edge.
    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(hs_rise));

    // R7: a clear with data 1 lowers the flag when no edge competes.
    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && clr_wr && clr_data && !hs_rise) |=> !ovf);
endmodule

bind hsync_gate_counter hsync_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise),
    .win_end (win_end),
    .vgate   (cur_vsync_gate),
    .clr_wr  (ovf_clr_wr),
    .clr_data(ovf_clr_data),
    .hcount  (hcount),
    .ovf     (hcount_ovf)
);

// File: tb/hsync_gate_counter_test.sv
`timescale 1ns/1ps
module hsync_gate_counter_test;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsync_in = 1'b0, vsync_in = 1'b0, tick_8us = 1'b1;
    logic          mode_wr = 1'b0, mode_vsync_gate = 1'b1, mode_long_win = 1'b1;
    logic          ovf_clr_wr = 1'b0, ovf_clr_data = 1'b0;
    logic [CW-1:0] hcount;
    logic          hcount_ovf, cur_vsync_gate, cur_long_win;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hsync_gate_counter uut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .tick_8us(tick_8us), .mode_wr(mode_wr), .mode_vsync_gate(mode_vsync_gate),
        .mode_long_win(mode_long_win), .ovf_clr_wr(ovf_clr_wr),
        .ovf_clr_data(ovf_clr_data), .hcount(hcount), .hcount_ovf(hcount_ovf),
        .cur_vsync_gate(cur_vsync_gate), .cur_long_win(cur_long_win)
    );

    function automatic int win_ticks(bit long_win);
        return long_win ? 4096 : 2048;
    endfunction

    function automatic int sat_count(int edges);
        return (edges > 16383) ? 16383 : edges;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic hpulse(int lo);
        @(negedge clk) hsync_in = 1'b1;
        @(negedge clk) hsync_in = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic vpulse();
        @(negedge clk) vsync_in = 1'b1;
        @(negedge clk) vsync_in = 1'b0;
    endtask

    // Returns with cyc equal to the accepting edge, 1 ns after it.
    task automatic write_mode(bit vg, bit lw, output int w);
        @(negedge clk);
        mode_wr = 1'b1; mode_vsync_gate = vg; mode_long_win = lw;
        @(posedge clk); #1;
        w = cyc;
        mode_wr = 1'b0;
    endtask

    task automatic clr(bit d);
        @(negedge clk) begin ovf_clr_wr = 1'b1; ovf_clr_data = d; end
        @(negedge clk) ovf_clr_wr = 1'b0;
    endtask

    task automatic wait_to(int target);
        while (cyc != target) begin @(posedge clk); #1; end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int w, n, m, lw;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        chk("R3 gate bit", int'(cur_vsync_gate), 1);
        chk("R3 length bit", int'(cur_long_win), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 result", int'(hcount), 0);
        chk("R3 flag", int'(hcount_ovf), 0);

        // R1 directed: open a window, count 5.
        vpulse(); settle();
        chk("R1 empty window", int'(hcount), 0);
        for (int i = 0; i < 5; i++) hpulse(2);
        settle(); vpulse(); settle();
        chk("R1 five edges", int'(hcount), 5);

        // R8: a long high level counts once.
        @(negedge clk) hsync_in = 1'b1;
        repeat (20) @(negedge clk);
        hsync_in = 1'b0;
        settle(); vpulse(); settle();
        chk("R8 held level", int'(hcount), 1);

        // R9: edge coinciding with a close goes to the new window.
        for (int i = 0; i < 3; i++) hpulse(1);
        settle();
        @(negedge clk) begin hsync_in = 1'b1; vsync_in = 1'b1; end
        @(negedge clk) begin hsync_in = 1'b0; vsync_in = 1'b0; end
        settle();
        chk("R9 old window", int'(hcount), 3);
        hpulse(1); hpulse(3);
        settle(); vpulse(); settle();
        chk("R9 new window", int'(hcount), 3);

        // R1 random windows.
        for (int k = 0; k < 24; k++) begin
            n = int'($urandom_range(40, 0));
            for (int i = 0; i < n; i++) hpulse(int'($urandom_range(3, 1)));
            settle(); vpulse(); settle();
            chk("R1 random window", int'(hcount), n);
        end

        // R6 overflow and saturation.
        for (int i = 0; i < 16383; i++) hpulse(1);
        settle();
        chk("R6 no flag at max", int'(hcount_ovf), 0);
        hpulse(1); settle();
        chk("R6 flag set", int'(hcount_ovf), 1);
        clr(1'b0); settle();
        chk("R7 clear with 0 ignored", int'(hcount_ovf), 1);
        clr(1'b1); @(negedge clk);
        chk("R7 clear with 1", int'(hcount_ovf), 0);
        vpulse(); settle();
        chk("R6 saturated result", int'(hcount), sat_count(16384));
        chk("R6 flag stays clear", int'(hcount_ovf), 0);

        // R7: clear leaves the running count alone.
        for (int i = 0; i < 5; i++) hpulse(2);
        settle(); clr(1'b1);
        for (int i = 0; i < 7; i++) hpulse(1);
        settle(); vpulse(); settle();
        chk("R7 count kept across clear", int'(hcount), 12);

        // R2/R10 short internal window.
        write_mode(1'b0, 1'b0, w);
        chk("R10 gate bit written", int'(cur_vsync_gate), 0);
        chk("R10 length bit written", int'(cur_long_win), 0);
        n = int'($urandom_range(30, 4));
        for (int i = 0; i < n; i++) hpulse(2);
        wait_to(w + win_ticks(1'b0) - 1);
        chk("R10 no close before 2048 ticks", int'(hcount), 12);
        @(posedge clk); #1;
        chk("R2 short window count", int'(hcount), n);
        // R5: vertical sync ignored in internal mode.
        m = int'($urandom_range(30, 4));
        for (int i = 0; i < m; i++) hpulse(1);
        vpulse(); settle();
        chk("R5 vsync ignored", int'(hcount), n);
        wait_to(w + 2 * win_ticks(1'b0) - 1);
        chk("R4 result held", int'(hcount), n);
        @(posedge clk); #1;
        chk("R2 back to back window", int'(hcount), m);

        // R2 long window with a tick gap.
        write_mode(1'b0, 1'b1, w);
        tick_8us = 1'b0;
        n = int'($urandom_range(30, 4));
        for (int i = 0; i < n; i++) hpulse(2);
        wait_to(w + 100);
        tick_8us = 1'b1;
        lw = win_ticks(1'b1);
        wait_to(w + 100 + lw - 1);
        chk("R2 ticks not cycles", int'(hcount), m);
        @(posedge clk); #1;
        chk("R2 long window count", int'(hcount), n);

        // R10: back to vertical sync gating restarts the counter.
        for (int i = 0; i < 6; i++) hpulse(1);
        settle();
        write_mode(1'b1, 1'b1, w);
        for (int i = 0; i < 4; i++) hpulse(1);
        settle(); vpulse(); settle();
        chk("R10 restart drops old edges", int'(hcount), 4);

        finished = 1'b1;
        summary();
    end
endmodule